// File: doc/BRIEF.md
# Burst Coefficient Upload Controller

This block sits behind a host register interface made of a command register and two data registers. A write to the command register picks one of three jobs. The first loads the eight coefficients of a two-stage IIR filter: one pair of values arrives with the command, and three more pairs follow as burst data writes. The second fills the whole working coefficient memory from built-in default values. The third loads a test-stream sample set whose length the command gives. Samples then arrive two at a time through the two data registers.

A request flag paces the host. After every accepted write the flag rises for a fixed number of cycles while the block stores the held pair. The host sends the next pair only after the flag has dropped. A data write that arrives while the flag is high, or when no burst is open, is dropped and reported as a protocol error. A command written during a job is filtered out, so the job in progress continues without change. A one-cycle done pulse marks the end of each job. The consumers read the stored words through two read ports that have one cycle of latency.

Top module: `coef_upload_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, the outputs req, done, proto_err and cnt_clamped are all low.
- R2: Command code 0x04 stores data1/data2 as the first two IIR words. The next three accepted data writes each store a pair. Across the upload, coefficient slot FIR_WORDS+k holds the k-th word in arrival order (a11, b10, b11, a21, a22, b20, b21, b22), where FIR_WORDS = FIR1_TAPS+FIR2_TAPS.
- R3: req goes high on the clock edge that accepts a command or data write. For uploads it stays high for exactly ACC_CYCLES cycles, and storage is written only while req is high.
- R4: A data write made while req is high, or made while idle without a command in the same cycle, stores nothing and causes a one-cycle proto_err pulse in the next cycle.
- R5: A command write while a job is in progress is ignored: it neither raises req nor changes the sequence. A data write in the same cycle as that command write is still accepted.
- R6: Code 0x05 ignores both data registers. It writes every coefficient slot i (0 to FIR_WORDS+7) with ((i+1)*0x012345) mod 2^24, one slot per cycle, with req high for FIR_WORDS+8 cycles.
- R7: Code 0x06 takes the sample count N from data1. Burst k stores data1 at sample address 2k and data2 at address 2k+1. When N is odd, the last data2 is dropped and address N keeps its earlier value.
- R8: done is a single-cycle pulse. It occurs in the first cycle in which req is low after the last write of a job, and the block then accepts a new command.
- R9: A count above SMP_DEPTH is clamped to SMP_DEPTH, and cnt_clamped pulses in the cycle after the command. A count of zero finishes after the command's hold time.
- R10: A command code other than 0x04, 0x05 or 0x06 is ignored: req stays low and no done pulse follows.
- R11: coef_rdata and smp_rdata show the word at the read address that was presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command code |
| dat_we | input | 1 | Burst data write strobe (both data registers) |
| dat1 | input | 24 | Data register 1 |
| dat2 | input | 24 | Data register 2 |
| req | output | 1 | Request/busy flag, high while a write is being absorbed |
| done | output | 1 | One-cycle job completion pulse |
| proto_err | output | 1 | One-cycle pulse for a rejected data write |
| cnt_clamped | output | 1 | One-cycle pulse when a sample count was clamped |
| coef_raddr | input | 5 | Coefficient read address |
| coef_rdata | output | 24 | Coefficient read data, one cycle latency |
| smp_raddr | input | 8 | Sample read address |
| smp_rdata | output | 24 | Sample read data, one cycle latency |

## Verification
A command rewrite can land in the same cycle as a burst data write. On the last IIR pair the bench drives a different command code together with the data strobe. It expects the pair to be stored, the normal hold length and a done pulse, with no copy of the defaults. A lone command rewrite between pairs must leave req low, and the contents read back later must match the uninterrupted sequence. A data write injected during the hold must produce proto_err and leave the stored values unchanged.

// File: rtl/coef_upload_pkg.sv
package coef_upload_pkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_IIR,
    CMD_ROM,
    CMD_SMP
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAIT,
    ST_COPY
  } seq_state_e;

  localparam int IIR_WORDS = 8;

  // built-in default word for coefficient slot idx
  function automatic logic [31:0] rom_word(input logic [31:0] idx);
    return (idx + 32'd1) * 32'h0001_2345;
  endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import coef_upload_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] IIR_CODE = 8'h04,
  parameter logic [CODE_W-1:0] ROM_CODE = 8'h05,
  parameter logic [CODE_W-1:0] SMP_CODE = 8'h06
) (
  input  logic [CODE_W-1:0] code,
  output cmd_kind_e         kind
);

  always_comb begin
    if (code == IIR_CODE)      kind = CMD_IIR;
    else if (code == ROM_CODE) kind = CMD_ROM;
    else if (code == SMP_CODE) kind = CMD_SMP;
    else                       kind = CMD_NONE;
  end

endmodule

// File: rtl/word_ram.sv
module word_ram #(
  parameter int W     = 24,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/upload_seq.sv
module upload_seq
  import coef_upload_pkg::*;
#(
  parameter int W          = 24,
  parameter int FIR_WORDS  = 10,
  parameter int SMP_DEPTH  = 256,
  parameter int ACC_CYCLES = 4,
  parameter int CAW        = 5,
  parameter int SAW        = 8,
  parameter int CNTW       = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_we,
  input  cmd_kind_e       kind,
  input  logic            dat_we,
  input  logic [W-1:0]    dat1,
  input  logic [W-1:0]    dat2,
  output logic            req,
  output logic            done,
  output logic            proto_err,
  output logic            cnt_clamped,
  output logic            coef_we,
  output logic [CAW-1:0]  coef_waddr,
  output logic            smp_we,
  output logic [SAW-1:0]  smp_waddr,
  output logic [W-1:0]    wr_data
);

  localparam int COEF_WORDS = FIR_WORDS + IIR_WORDS;
  localparam int ACC_EFF    = (ACC_CYCLES < 2) ? 2 : ACC_CYCLES;
  localparam int TMAX       = (ACC_EFF > COEF_WORDS) ? ACC_EFF : COEF_WORDS;
  localparam int TW         = $clog2(TMAX) + 1;

  seq_state_e      state;
  logic            is_smp;
  logic [W-1:0]    hold1, hold2;
  logic [1:0]      hold_n;
  logic [CNTW-1:0] remain, wptr;
  logic [TW-1:0]   tmr;
  logic            req_q, done_q, err_q, clamp_q;

  logic            idle, cmd_take, dat_take, hold_end, copy_end, hold_wr, over;
  logic [CNTW-1:0] n_req, take_n, offs;
  logic [31:0]     rom_full;

  assign idle     = (state == ST_IDLE);
  assign cmd_take = idle && cmd_we && (kind != CMD_NONE);
  assign dat_take = (state == ST_WAIT) && dat_we;
  assign over     = (dat1 > W'(SMP_DEPTH));
  assign n_req    = over ? CNTW'(SMP_DEPTH) : CNTW'(dat1);
  assign take_n   = (remain >= CNTW'(2)) ? CNTW'(2) : remain;
  assign hold_end = (state == ST_HOLD) && (tmr == TW'(ACC_EFF - 1));
  assign copy_end = (state == ST_COPY) && (tmr == TW'(COEF_WORDS - 1));
  assign hold_wr  = (state == ST_HOLD) &&
                    (((tmr == TW'(0)) && (hold_n != 2'd0)) ||
                     ((tmr == TW'(1)) && (hold_n == 2'd2)));
  assign offs     = wptr + CNTW'(tmr[0]);
  assign rom_full = rom_word(32'(tmr));

  // storage write port
  always_comb begin
    coef_we    = (state == ST_COPY) || (hold_wr && !is_smp);
    smp_we     = hold_wr && is_smp;
    smp_waddr  = SAW'(offs);
    if (state == ST_COPY) begin
      coef_waddr = CAW'(tmr);
      wr_data    = rom_full[W-1:0];
    end else begin
      coef_waddr = CAW'(FIR_WORDS) + CAW'(offs);
      wr_data    = tmr[0] ? hold2 : hold1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      is_smp  <= 1'b0;
      hold1   <= '0;
      hold2   <= '0;
      hold_n  <= 2'd0;
      remain  <= '0;
      wptr    <= '0;
      tmr     <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      clamp_q <= 1'b0;
      err_q   <= dat_we && !dat_take && !cmd_take;
      case (state)
        ST_IDLE: begin
          if (cmd_take) begin
            tmr   <= '0;
            req_q <= 1'b1;
            wptr  <= '0;
            case (kind)
              CMD_IIR: begin
                hold1  <= dat1;
                hold2  <= dat2;
                hold_n <= 2'd2;
                remain <= CNTW'(IIR_WORDS - 2);
                is_smp <= 1'b0;
                state  <= ST_HOLD;
              end
              CMD_SMP: begin
                hold_n  <= 2'd0;
                remain  <= n_req;
                is_smp  <= 1'b1;
                clamp_q <= over;
                state   <= ST_HOLD;
              end
              default: state <= ST_COPY;
            endcase
          end
        end
        ST_HOLD: begin
          if (hold_end) begin
            wptr  <= wptr + CNTW'(hold_n);
            req_q <= 1'b0;
            if (remain == '0) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_WAIT: begin
          if (dat_we) begin
            hold1  <= dat1;
            hold2  <= dat2;
            hold_n <= take_n[1:0];
            remain <= remain - take_n;
            tmr    <= '0;
            req_q  <= 1'b1;
            state  <= ST_HOLD;
          end
        end
        default: begin
          if (copy_end) begin
            req_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
      endcase
    end
  end

  assign req         = req_q;
  assign done        = done_q;
  assign proto_err   = err_q;
  assign cnt_clamped = clamp_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!req_q && $past(req_q)));
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(dat_we));
  // R9
  clamp_src_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_q |-> $past(cmd_we && kind == CMD_SMP));
  // R3
  wr_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_we || smp_we) |-> req_q);
  // R5
  busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && cmd_we && !dat_we) |=>
      (state == ST_WAIT && !req_q && $stable(remain)));
  // R10
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_we && kind == CMD_NONE) |=> (!req_q && state == ST_IDLE));
  // R6
  copy_we_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COPY) |-> (coef_we && !smp_we));

endmodule

// File: rtl/coef_upload_ctrl.sv
module coef_upload_ctrl
  import coef_upload_pkg::*;
#(
  parameter int COEF_W     = 24,
  parameter int FIR1_TAPS  = 6,
  parameter int FIR2_TAPS  = 4,
  parameter int SMP_DEPTH  = 256,
  parameter int ACC_CYCLES = 4,
  localparam int FIR_WORDS  = FIR1_TAPS + FIR2_TAPS,
  localparam int COEF_WORDS = FIR_WORDS + IIR_WORDS,
  localparam int CAW        = $clog2(COEF_WORDS),
  localparam int SAW        = $clog2(SMP_DEPTH),
  localparam int CNTW       = $clog2(SMP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_code,
  input  logic              dat_we,
  input  logic [COEF_W-1:0] dat1,
  input  logic [COEF_W-1:0] dat2,
  output logic              req,
  output logic              done,
  output logic              proto_err,
  output logic              cnt_clamped,
  input  logic [CAW-1:0]    coef_raddr,
  output logic [COEF_W-1:0] coef_rdata,
  input  logic [SAW-1:0]    smp_raddr,
  output logic [COEF_W-1:0] smp_rdata
);

  cmd_kind_e         kind;
  logic              coef_we, smp_we;
  logic [CAW-1:0]    coef_waddr;
  logic [SAW-1:0]    smp_waddr;
  logic [COEF_W-1:0] wr_data;

  cmd_decode #(.CODE_W(8)) u_dec (
    .code (cmd_code),
    .kind (kind)
  );

  upload_seq #(
    .W          (COEF_W),
    .FIR_WORDS  (FIR_WORDS),
    .SMP_DEPTH  (SMP_DEPTH),
    .ACC_CYCLES (ACC_CYCLES),
    .CAW        (CAW),
    .SAW        (SAW),
    .CNTW       (CNTW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_we      (cmd_we),
    .kind        (kind),
    .dat_we      (dat_we),
    .dat1        (dat1),
    .dat2        (dat2),
    .req         (req),
    .done        (done),
    .proto_err   (proto_err),
    .cnt_clamped (cnt_clamped),
    .coef_we     (coef_we),
    .coef_waddr  (coef_waddr),
    .smp_we      (smp_we),
    .smp_waddr   (smp_waddr),
    .wr_data     (wr_data)
  );

  word_ram #(.W(COEF_W), .DEPTH(COEF_WORDS), .AW(CAW)) u_coef_ram (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_waddr),
    .wdata (wr_data),
    .raddr (coef_raddr),
    .rdata (coef_rdata)
  );

  word_ram #(.W(COEF_W), .DEPTH(SMP_DEPTH), .AW(SAW)) u_smp_ram (
    .clk   (clk),
    .we    (smp_we),
    .waddr (smp_waddr),
    .wdata (wr_data),
    .raddr (smp_raddr),
    .rdata (smp_rdata)
  );

endmodule

// File: tb/coef_upload_ctrl_test.sv
module coef_upload_ctrl_test;

  localparam int FIRW  = 10;
  localparam int TOTAL = FIRW + 8;
  localparam int DEPTH = 256;
  localparam int ACC   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0, dat_we = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [23:0] dat1 = '0, dat2 = '0;
  logic        req, done, proto_err, cnt_clamped;
  logic [4:0]  coef_raddr = '0;
  logic [23:0] coef_rdata;
  logic [7:0]  smp_raddr = '0;
  logic [23:0] smp_rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [23:0] exp_coef [TOTAL];
  logic [23:0] exp_smp  [DEPTH];
  bit          smp_known[DEPTH];

  coef_upload_ctrl uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .dat_we(dat_we), .dat1(dat1), .dat2(dat2), .req(req), .done(done),
    .proto_err(proto_err), .cnt_clamped(cnt_clamped),
    .coef_raddr(coef_raddr), .coef_rdata(coef_rdata),
    .smp_raddr(smp_raddr), .smp_rdata(smp_rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [23:0] dflt(input int i);
    logic [31:0] v;
    v = (i + 1) * 32'h0001_2345;
    return v[23:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input bit c, input bit d, input logic [7:0] code,
                      input logic [23:0] a, input logic [23:0] b);
    int gap = $urandom_range(0, 3);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    cmd_we = c; dat_we = d; cmd_code = code; dat1 = a; dat2 = b;
    @(negedge clk);
    cmd_we = 0; dat_we = 0;
  endtask

  task automatic track(input int exp_len, input bit exp_done, input bit inject,
                       input string tag);
    int len = 0;
    while (req === 1'b1 && len < 2000) begin
      len++;
      if (inject && len == 1) begin
        dat_we = 1; dat1 = 24'hBAD0BA; dat2 = 24'hBAD0BB;
      end
      if (inject && len == 2) begin
        dat_we = 0;
        check(proto_err === 1'b1, "R4", "proto_err after write during req", proto_err, 1);
      end
      @(negedge clk);
    end
    check(len == exp_len, "R3", {tag, " req length"}, len, exp_len);
    check(done === exp_done, "R8", {tag, " done at req fall"}, done, exp_done);
    if (exp_done) begin
      @(negedge clk);
      check(done === 1'b0, "R8", "done single cycle", done, 0);
    end
  endtask

  task automatic verify_coef(input string tag);
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk); coef_raddr = 5'(i);
      @(negedge clk);
      check(coef_rdata === exp_coef[i], tag, $sformatf("coef slot %0d (R11 read)", i),
            coef_rdata, exp_coef[i]);
    end
  endtask

  task automatic verify_smp(input int upto);
    for (int i = 0; i <= upto && i < DEPTH; i++) begin
      if (smp_known[i]) begin
        @(negedge clk); smp_raddr = 8'(i);
        @(negedge clk);
        check(smp_rdata === exp_smp[i], "R7", $sformatf("sample %0d", i),
              smp_rdata, exp_smp[i]);
      end
    end
  endtask

  task automatic iir_upload(input bit inject, input bit lone_cmd, input bit cmd_with_data);
    logic [23:0] v [8];
    for (int i = 0; i < 8; i++) v[i] = 24'($urandom);
    send(1, 0, 8'h04, v[0], v[1]);
    track(ACC, 0, 0, "R2 first pair");
    for (int p = 0; p < 3; p++) begin
      if (p == 1 && lone_cmd) begin
        send(1, 0, 8'h06, 24'd5, 24'd0);
        check(req === 1'b0, "R5", "lone command mid-burst raises req", req, 0);
      end
      send(cmd_with_data && p == 2, 1, 8'h05, v[2+2*p], v[3+2*p]);
      track(ACC, p == 2, inject && p == 1, "R2 burst");
    end
    for (int i = 0; i < 8; i++) exp_coef[FIRW+i] = v[i];
    verify_coef("R2");
  endtask

  task automatic smp_upload(input int n, input bit clamp_exp);
    int ne = (n > DEPTH) ? DEPTH : n;
    logic [23:0] a, b;
    send(1, 0, 8'h06, 24'(n), 24'($urandom));
    check(cnt_clamped === clamp_exp, "R9", "clamp flag", cnt_clamped, clamp_exp);
    track(ACC, ne == 0, 0, "R9 count cmd");
    for (int k = 0; 2*k < ne; k++) begin
      a = 24'($urandom); b = 24'($urandom);
      send(0, 1, 8'h00, a, b);
      track(ACC, 2*k + 2 >= ne, 0, "R7 burst");
      exp_smp[2*k] = a; smp_known[2*k] = 1;
      if (2*k + 1 < ne) begin
        exp_smp[2*k+1] = b; smp_known[2*k+1] = 1;
      end
    end
    verify_smp(ne);
  endtask

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < DEPTH; i++) smp_known[i] = 0;
    for (int i = 0; i < TOTAL; i++) exp_coef[i] = 'x;
    repeat (3) @(negedge clk);
    check({req, done, proto_err, cnt_clamped} === 4'b0, "R1", "outputs in reset",
          {req, done, proto_err, cnt_clamped}, 0);
    rst = 0;
    @(negedge clk);
    check({req, done, proto_err, cnt_clamped} === 4'b0, "R1", "outputs after reset",
          {req, done, proto_err, cnt_clamped}, 0);

    // R10 unknown codes
    send(1, 0, 8'h07, 24'h1, 24'h2);
    begin
      bit seen = 0;
      for (int i = 0; i < 6; i++) begin
        if (req !== 1'b0 || done !== 1'b0) seen = 1;
        @(negedge clk);
      end
      check(!seen, "R10", "req/done after code 0x07", seen, 0);
    end
    send(1, 0, 8'h00, 24'h0, 24'h0);
    check(req === 1'b0, "R10", "req after code 0x00", req, 0);

    // R4 lone data write in idle
    send(0, 1, 8'h00, 24'h123456, 24'h654321);
    check(proto_err === 1'b1, "R4", "proto_err on idle data write", proto_err, 1);
    @(negedge clk);
    check(proto_err === 1'b0, "R4", "proto_err one cycle", proto_err, 0);

    // R6 default copy, data registers carry junk
    send(1, 0, 8'h05, 24'hFFFFFF, 24'hABCDEF);
    track(TOTAL, 1, 0, "R6 copy");
    for (int i = 0; i < TOTAL; i++) exp_coef[i] = dflt(i);
    verify_coef("R6");

    // R2 R4 R5: IIR with injected error, lone command and command+data
    iir_upload(1, 1, 1);

    // R7 odd count keeps address N
    smp_upload(10, 0);
    smp_upload(9, 0);
    // R9 zero and clamp
    smp_upload(0, 0);
    smp_upload(300, 1);

    // random mix
    for (int r = 0; r < 4; r++) smp_upload($urandom_range(1, 40), 0);
    iir_upload(0, 0, 0);
    verify_smp(DEPTH - 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule